// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This block produces the vertical timing for an image array that is read with two row pointers: a read pointer, which selects the row being sampled, and a reset pointer, which trails it and clears rows to start their exposure. A frame-start pulse captures the configuration and loads the read pointer with a programmed start row. It also emits a read-sync pulse. Each rising edge of the row clock then moves the read pointer down one row and advances an exposure counter. When that counter meets the programmed exposure value, the reset pointer is loaded from the same start row and a reset-sync pulse is emitted. From then on the reset pointer steps with every row-clock edge. A line counter ends the frame with a single end-of-frame pulse.

Two modes change the pacing. In paired mode, the row clock ticks twice per line: the exposure and line counts step only on every second edge, and end-of-frame waits one further edge so that the row under the reset pointer is also read. In shared mode, the reset pointer outputs simply mirror the read pointer, so each row is swept by both at once. Row pointers are exposed as binary indices that wrap over a configurable array height. The row decoders and the pixel array lie outside the block.

Top module: `row_seq_top`

## Requirements
- R1: The cycle after `frame_start` is sampled high, `left_sync` is high for one cycle and `left_row` equals the `cfg_start_row` value sampled with that pulse.
- R2: During a frame, each row-clock rising edge (`row_clk` sampled 1 after being sampled 0 on the previous clock) moves `left_row` up by one on the following cycle, from `ROWS-1` back to 0.
- R3: `right_sync` pulses for one cycle, with `right_row` equal to the captured start row, when the exposure count reaches `cfg_int_time`. With `cfg_int_time` = 0 it pulses together with `left_sync`.
- R4: Once loaded, `right_row` moves up by one on every row-clock rising edge of the frame, wrapping like `left_row`.
- R5: Outside paired mode, `eof` pulses for one cycle on the edge where the line count reaches `cfg_lines` (at least 1). After it, row-clock edges move no pointer and raise no pulse until the next `frame_start`.
- R6: In paired mode (`cfg_dbl_clk` = 1), the exposure and line counts step only on the 2nd, 4th, 6th... edge of the frame.
- R7: In paired mode, `eof` pulses on the edge that follows the one where the line count reaches `cfg_lines`.
- R8: In shared mode (`cfg_fast_rst` = 1), `right_row` equals `left_row` in every cycle and `right_sync` pulses exactly with `left_sync`.
- R9: Configuration inputs are captured only on `frame_start`. Changing them mid-frame alters neither the timing nor the rows of that frame.
- R10: A `frame_start` arriving mid-frame restarts all counts. When it coincides with a row-clock edge, that edge is not counted.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame start pulse, synchronous to `clk` |
| row_clk | input | 1 | Row clock level, already synchronous to `clk` |
| cfg_start_row | input | ROW_W | First row loaded into both pointers |
| cfg_int_time | input | CNT_W | Exposure length in counted row steps |
| cfg_lines | input | CNT_W | Lines per frame |
| cfg_dbl_clk | input | 1 | Paired mode: two row-clock edges per line |
| cfg_fast_rst | input | 1 | Shared mode: reset pointer mirrors read pointer |
| left_sync | output | 1 | Read pointer load pulse |
| right_sync | output | 1 | Reset pointer load pulse |
| eof | output | 1 | End-of-frame pulse |
| left_row | output | ROW_W | Read pointer row index |
| right_row | output | ROW_W | Reset pointer row index |

## Verification
The bench builds the block with `ROWS` = 6 and `CNT_W` = 8. A six-row array lets a frame that starts at row 4 wrap both pointers within a few edges, so the wrap, the trailing reset pointer and the end of frame all fit into short directed runs. An 8-bit count keeps exposure and line limits small, while the paired-mode cases show the half-rate stepping and the one-edge end-of-frame delay within six edges.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;
  typedef struct packed {
    logic dbl;   // two row-clock edges per line
    logic fast;  // reset pointer mirrors read pointer
  } seq_mode_t;
endpackage

// File: rtl/row_edge_det.sv
module row_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= level;
  end

  assign rise = level & ~lvl_q;
endmodule

// File: rtl/row_ptr.sv
module row_ptr #(
  parameter int ROWS  = 480,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_val,
  input  logic             adv,
  output logic [ROW_W-1:0] ptr
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | adv;
    if (load)              ptr_d = load_val;
    else if (ptr_q == LAST) ptr_d = '0;
    else                   ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import row_seq_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             rise,
  input  logic [ROW_W-1:0] cfg_start_row,
  input  logic [CNT_W-1:0] cfg_int_time,
  input  logic [CNT_W-1:0] cfg_lines,
  input  seq_mode_t        cfg_mode,
  output logic             active,
  output seq_mode_t        mode,
  output logic [ROW_W-1:0] start_row,
  output logic [ROW_W-1:0] load_row,
  output logic             left_load,
  output logic             left_adv,
  output logic             right_load,
  output logic             right_adv,
  output logic             left_sync,
  output logic             right_sync,
  output logic             eof
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] int_q, int_d, line_q, line_d;
  logic [CNT_W-1:0] int_lim_q, int_lim_d, line_lim_q, line_lim_d;
  logic             half_q, half_d, armed_q, armed_d, ron_q, ron_d;
  logic [ROW_W-1:0] start_q, start_d;
  seq_mode_t        mode_q, mode_d;
  logic             ls_q, rs_q, eof_q;

  logic             ev, step, int_hit, line_hit, eof_ev;
  logic [CNT_W-1:0] int_nx, line_nx;

  always_comb begin
    ev       = active_q & rise & ~frame_start;
    step     = ~mode_q.dbl | half_q;
    int_nx   = int_q + 1'b1;
    line_nx  = line_q + 1'b1;
    int_hit  = ev & step & ~ron_q & (int_nx == int_lim_q);
    line_hit = ev & step & (line_nx == line_lim_q);
    eof_ev   = mode_q.dbl ? (ev & armed_q) : line_hit;

    left_load  = frame_start;
    left_adv   = ev;
    right_load = frame_start ? (cfg_int_time == '0) : int_hit;
    right_adv  = ev & ron_q;
    load_row   = frame_start ? cfg_start_row : start_q;
  end

  always_comb begin
    active_d   = active_q;
    int_d      = int_q;
    line_d     = line_q;
    half_d     = half_q;
    armed_d    = armed_q;
    ron_d      = ron_q;
    start_d    = start_q;
    int_lim_d  = int_lim_q;
    line_lim_d = line_lim_q;
    mode_d     = mode_q;
    if (frame_start) begin
      active_d   = 1'b1;
      int_d      = '0;
      line_d     = '0;
      half_d     = 1'b0;
      armed_d    = 1'b0;
      ron_d      = (cfg_int_time == '0);
      start_d    = cfg_start_row;
      int_lim_d  = cfg_int_time;
      line_lim_d = cfg_lines;
      mode_d     = cfg_mode;
    end else if (ev) begin
      half_d = mode_q.dbl & ~half_q;
      if (step & ~ron_q)            int_d   = int_nx;
      if (int_hit)                  ron_d   = 1'b1;
      if (step)                     line_d  = line_nx;
      if (line_hit & mode_q.dbl)    armed_d = 1'b1;
      if (eof_ev)                   active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      int_q      <= '0;
      line_q     <= '0;
      half_q     <= 1'b0;
      armed_q    <= 1'b0;
      ron_q      <= 1'b0;
      start_q    <= '0;
      int_lim_q  <= '0;
      line_lim_q <= '0;
      mode_q     <= '0;
      ls_q       <= 1'b0;
      rs_q       <= 1'b0;
      eof_q      <= 1'b0;
    end else begin
      active_q   <= active_d;
      int_q      <= int_d;
      line_q     <= line_d;
      half_q     <= half_d;
      armed_q    <= armed_d;
      ron_q      <= ron_d;
      start_q    <= start_d;
      int_lim_q  <= int_lim_d;
      line_lim_q <= line_lim_d;
      mode_q     <= mode_d;
      ls_q       <= left_load;
      rs_q       <= right_load;
      eof_q      <= eof_ev;
    end
  end

  assign active     = active_q;
  assign mode       = mode_q;
  assign start_row  = start_q;
  assign left_sync  = ls_q;
  assign right_sync = mode_q.fast ? ls_q : rs_q;
  assign eof        = eof_q;
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
  import row_seq_pkg::*;
#(
  parameter int ROWS  = 480,
  parameter int CNT_W = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             row_clk,
  input  logic [ROW_W-1:0] cfg_start_row,
  input  logic [CNT_W-1:0] cfg_int_time,
  input  logic [CNT_W-1:0] cfg_lines,
  input  logic             cfg_dbl_clk,
  input  logic             cfg_fast_rst,
  output logic             left_sync,
  output logic             right_sync,
  output logic             eof,
  output logic [ROW_W-1:0] left_row,
  output logic [ROW_W-1:0] right_row
);
  localparam int NPTR = 2;

  logic             row_rise;
  logic             active;
  seq_mode_t        mode_in, mode_q;
  logic [ROW_W-1:0] start_q, load_row;
  logic [NPTR-1:0]  ptr_ld, ptr_adv;
  logic [ROW_W-1:0] ptr [NPTR];

  assign mode_in.dbl  = cfg_dbl_clk;
  assign mode_in.fast = cfg_fast_rst;

  row_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (row_clk),
    .rise  (row_rise)
  );

  frame_ctrl #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .rise          (row_rise),
    .cfg_start_row (cfg_start_row),
    .cfg_int_time  (cfg_int_time),
    .cfg_lines     (cfg_lines),
    .cfg_mode      (mode_in),
    .active        (active),
    .mode          (mode_q),
    .start_row     (start_q),
    .load_row      (load_row),
    .left_load     (ptr_ld[0]),
    .left_adv      (ptr_adv[0]),
    .right_load    (ptr_ld[1]),
    .right_adv     (ptr_adv[1]),
    .left_sync     (left_sync),
    .right_sync    (right_sync),
    .eof           (eof)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    row_ptr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_ld[g]),
      .load_val (load_row),
      .adv      (ptr_adv[g]),
      .ptr      (ptr[g])
    );
  end

  assign left_row  = ptr[0];
  assign right_row = mode_q.fast ? ptr[0] : ptr[1];
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk #(
  parameter int ROWS  = 480,
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             row_rise,
  input logic             active,
  input logic             fast_q,
  input logic [ROW_W-1:0] cfg_start_row,
  input logic [ROW_W-1:0] start_q,
  input logic [ROW_W-1:0] left_row,
  input logic [ROW_W-1:0] right_row,
  input logic             left_sync,
  input logic             right_sync,
  input logic             eof
);
  // R1
  fs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (left_sync && left_row == $past(cfg_start_row)));

  // R2
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && row_rise && !frame_start) |=>
      (int'(left_row) == ((int'($past(left_row)) == ROWS - 1) ? 0 : int'($past(left_row)) + 1)));

  // R2
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left_row) < ROWS);

  // R3
  rsync_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (right_sync && !fast_q) |-> (right_row == start_q));

  // R5
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !frame_start) |=> ($stable(left_row) && !left_sync && !eof));
endmodule

bind row_seq_top row_seq_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .row_rise      (row_rise),
  .active        (active),
  .fast_q        (mode_q.fast),
  .cfg_start_row (cfg_start_row),
  .start_q       (start_q),
  .left_row      (left_row),
  .right_row     (right_row),
  .left_sync     (left_sync),
  .right_sync    (right_sync),
  .eof           (eof)
);

// File: tb/sim_row_seq_top.sv
module sim_row_seq_top;
  localparam int ROWS  = 6;
  localparam int CNT_W = 8;
  localparam int ROW_W = $clog2(ROWS);

  logic             clk, rst_n, frame_start, row_clk;
  logic [ROW_W-1:0] cfg_start_row;
  logic [CNT_W-1:0] cfg_int_time, cfg_lines;
  logic             cfg_dbl_clk, cfg_fast_rst;
  logic             left_sync, right_sync, eof;
  logic [ROW_W-1:0] left_row, right_row;

  int n_chk = 0, n_bad = 0;
  int edge_no = 0, eof_at = -1, rs_at = -1;
  int cyc = 0;

  row_seq_top #(.ROWS(ROWS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_clk(row_clk),
    .cfg_start_row(cfg_start_row), .cfg_int_time(cfg_int_time),
    .cfg_lines(cfg_lines), .cfg_dbl_clk(cfg_dbl_clk), .cfg_fast_rst(cfg_fast_rst),
    .left_sync(left_sync), .right_sync(right_sync), .eof(eof),
    .left_row(left_row), .right_row(right_row)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  int  m_left, m_right, m_int, m_line, m_start, m_ilim, m_llim;
  bit  m_act, m_ron, m_half, m_armed, m_dbl, m_fast, m_prev;
  bit  m_ls, m_rs, m_eof;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_right = 0; m_int = 0; m_line = 0; m_start = 0;
      m_ilim = 0; m_llim = 0; m_act = 0; m_ron = 0; m_half = 0;
      m_armed = 0; m_dbl = 0; m_fast = 0; m_prev = 0;
      m_ls = 0; m_rs = 0; m_eof = 0;
    end else begin
      bit rise, step, hit;
      rise = row_clk && !m_prev;
      m_prev = row_clk;
      m_ls = 0; m_rs = 0; m_eof = 0;
      if (frame_start) begin
        m_start = int'(cfg_start_row); m_ilim = int'(cfg_int_time);
        m_llim = int'(cfg_lines); m_dbl = cfg_dbl_clk; m_fast = cfg_fast_rst;
        m_act = 1; m_left = m_start; m_ls = 1;
        m_int = 0; m_line = 0; m_half = 0; m_armed = 0;
        m_ron = (m_ilim == 0);
        if (m_ron) begin m_right = m_start; m_rs = 1; end
      end else if (rise && m_act) begin
        m_left = (m_left + 1) % ROWS;
        if (m_ron) m_right = (m_right + 1) % ROWS;
        step = !m_dbl || m_half;
        if (m_dbl) m_half = !m_half;
        if (step && !m_ron) begin
          m_int = (m_int + 1) % 256;
          if (m_int == m_ilim) begin m_ron = 1; m_right = m_start; m_rs = 1; end
        end
        hit = 0;
        if (step) begin m_line = (m_line + 1) % 256; hit = (m_line == m_llim); end
        if (m_dbl) begin
          if (m_armed) begin m_eof = 1; m_act = 0; end
          else if (hit) m_armed = 1;
        end else if (hit) begin
          m_eof = 1; m_act = 0;
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(int'(left_sync), int'(m_ls), "R1 left_sync");
      chk(int'(left_row), m_left, "R2 left_row");
      chk(int'(right_sync), int'(m_fast ? m_ls : m_rs), "R3 right_sync");
      chk(int'(right_row), m_fast ? m_left : m_right, "R4 right_row");
      chk(int'(eof), int'(m_eof), "R5 eof");
      if (eof) eof_at = edge_no;
      if (right_sync) rs_at = edge_no;
    end
  end

  task automatic new_frame(input int st, input int it, input int ln,
                           input bit dbl, input bit fst, input bit with_edge);
    @(negedge clk);
    cfg_start_row = ROW_W'(st); cfg_int_time = CNT_W'(it); cfg_lines = CNT_W'(ln);
    cfg_dbl_clk = dbl; cfg_fast_rst = fst;
    frame_start = 1'b1;
    if (with_edge) row_clk = 1'b1;
    edge_no = 0; eof_at = -1; rs_at = -1;
    @(negedge clk);
    frame_start = 1'b0; row_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      row_clk = 1'b1; edge_no++;
      @(negedge clk);
      row_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [ROW_W-1:0] hold;
    rst_n = 1'b0; frame_start = 1'b0; row_clk = 1'b0;
    cfg_start_row = '0; cfg_int_time = '0; cfg_lines = '0;
    cfg_dbl_clk = 1'b0; cfg_fast_rst = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(int'({left_sync, right_sync, eof}), 0, "R11 pulses after reset");
    chk(int'({left_row, right_row}), 0, "R11 rows after reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // normal frame, wraps from row 5 to 0
    new_frame(4, 2, 7, 0, 0, 0);
    edges(8);
    chk(rs_at, 2, "R3 right sync at exposure limit");
    chk(eof_at, 7, "R5 eof at line limit");
    hold = left_row;
    edges(2);
    chk(int'(left_row), int'(hold), "R5 edges ignored after eof");

    // zero exposure loads both pointers together
    new_frame(2, 0, 3, 0, 0, 0);
    chk(rs_at, 0, "R3 zero exposure right sync with left sync");
    edges(4);
    chk(int'(right_row), int'(left_row), "R4 right follows left from same start");

    // paired mode
    new_frame(0, 1, 2, 1, 0, 0);
    edges(6);
    chk(rs_at, 2, "R6 exposure steps on second edge");
    chk(eof_at, 5, "R7 eof one edge after line limit");

    // shared mode
    new_frame(3, 3, 4, 0, 1, 0);
    chk(rs_at, 0, "R8 right sync with left sync");
    edges(2);
    chk(int'(right_row), int'(left_row), "R8 rows identical");
    edges(3);

    // configuration changes mid-frame have no effect
    new_frame(1, 2, 5, 0, 0, 0);
    edges(1);
    cfg_int_time = 8'd4; cfg_lines = 8'd2; cfg_start_row = 3'd5; cfg_dbl_clk = 1'b1;
    edges(5);
    chk(rs_at, 2, "R9 exposure limit kept");
    chk(eof_at, 5, "R9 line limit kept");

    // restart mid-frame, coinciding with a row-clock edge
    new_frame(0, 3, 4, 0, 0, 0);
    edges(2);
    new_frame(2, 3, 4, 0, 0, 1);
    chk(int'(left_row), 2, "R10 restart reloads start row");
    edges(5);
    chk(eof_at, 4, "R10 restarted line count");
    chk(rs_at, 3, "R10 restarted exposure count");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule